// File: doc/BRIEF.md
# Descriptor Ring DMA Pipe

This block is one unidirectional DMA pipe. It works through a circular ring of 8-byte descriptors kept in system memory. Software sets the ring base and the ring size in bytes, places descriptors in the ring, and then writes the producer byte offset to a doorbell register. The pipe then fetches each descriptor from its consumer offset up to, but not including, the producer offset. For each one it moves the stated number of bytes between a byte-stream peripheral port and a buffer in memory. When the consumer offset reaches the ring size, it wraps to zero.

A single request/acknowledge memory port carries both traffic types. Descriptor fetches are 32-bit reads. Data beats are single bytes. A control bit sets the direction. Per-descriptor flag bits decide which completions raise an event pulse. A halt register pauses the pipe at a safe point. A soft-reset register returns the whole pipe to its defaults.

Top module: `desc_ring_pipe`

## Requirements
- R1: Register index on `reg_addr_i` is: 0 control, 1 soft reset, 2 halt, 3 ring base, 4 ring size, 5 doorbell (producer byte offset), 6 consumer offset (read only, low 16 bits). Reads of every register are combinational.
- R2: The descriptor at consumer offset C is read as two 32-bit little-endian words. The word at base+C is the buffer address. In the word at base+C+4, bits 15:0 are the byte count and bits 31:16 are the flags. The pipe processes descriptors while the consumer offset differs from the doorbell offset. The pipe stops when the two offsets are equal.
- R3: After each descriptor the consumer offset advances by 8. It becomes 0 when it reaches the ring size.
- R4: With control bit 3 clear (memory to peripheral), buffer bytes are read at ascending addresses. A read's byte arrives in `mem_rdata_i[7:0]`. Each byte is presented on the tx stream, and `tx_valid_o` and `tx_data_o` are held until `tx_ready_i`.
- R5: With control bit 3 set (peripheral to memory), each byte accepted on the rx stream is written to the buffer at ascending addresses. Each write is a single-byte write on `mem_wdata_o`.
- R6: On completion, flag bit 15 gives a one-cycle `done_evt_o` pulse and flag bit 14 gives a one-cycle `eot_evt_o` pulse. Flag bit 13 has no effect on the pipe.
- R7: A descriptor with a byte count of zero completes without any data beat. Its flags still raise their events.
- R8: While halt bit 0 is 1, no new memory request is issued, no rx byte is accepted and no descriptor is started. Writing 0 resumes from the same point, and no byte is lost or repeated.
- R9: While soft-reset bit 0 is 1, all other registers, the consumer offset and the engine are held at zero, and register writes are ignored. Writing 0 releases the pipe.
- R10: Control bit 0 enables the pipe. While it is 0, no descriptor is started and `out_of_desc_o` stays low. Control bit 5 (system mode) is stored and reads back.
- R11: Ring base bits 2:0 always read as zero.
- R12: `mem_req_o` is held, with a stable address and write flag, until `mem_ack_i`.
- R13: `out_of_desc_o` is high when the pipe is enabled and idle with consumer equal to producer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (byte), else 32-bit read |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | 8 | Memory write byte |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 32 | Memory read word |
| tx_valid_o | output | 1 | Peripheral tx byte valid |
| tx_data_o | output | 8 | Peripheral tx byte |
| tx_ready_i | input | 1 | Peripheral tx ready |
| rx_valid_i | input | 1 | Peripheral rx byte valid |
| rx_data_i | input | 8 | Peripheral rx byte |
| rx_ready_o | output | 1 | Peripheral rx ready |
| done_evt_o | output | 1 | Processed-descriptor event pulse |
| eot_evt_o | output | 1 | Transfer-end event pulse |
| out_of_desc_o | output | 1 | Enabled, idle and ring empty |

## Verification
The assertions check the following on every cycle:
- the memory request stays held until acknowledged;
- a tx byte stays held until accepted;
- the consumer offset moves only in 8-byte steps or to zero;
- no request starts while halted;
- the idle flag excludes traffic and events;
- rx readiness matches the selected direction.

Only the bench scenarios can show the remaining behaviour:
- that bytes reach the right buffer in the right order;
- that the ring wraps at the programmed size;
- that a zero-length descriptor still raises its events;
- that halting in mid-descriptor neither loses nor repeats a byte;
- that soft reset clears every register.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned CNT_W     = 16;
  localparam int unsigned SLOT_B    = 8;
  localparam int unsigned FLG_INT   = 15;
  localparam int unsigned FLG_EOT   = 14;
  localparam int unsigned CTRL_EN   = 0;
  localparam int unsigned CTRL_P2M  = 3;
  localparam int unsigned CTRL_SYS  = 5;

  typedef enum logic [2:0] {
    REG_CTRL = 3'd0,
    REG_RST  = 3'd1,
    REG_HALT = 3'd2,
    REG_BASE = 3'd3,
    REG_SIZE = 3'd4,
    REG_BELL = 3'd5,
    REG_CONS = 3'd6
  } reg_idx_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_A,
    ST_FETCH_B,
    ST_RD,
    ST_TX,
    ST_RX,
    ST_WR,
    ST_DONE
  } eng_state_e;
endpackage

// File: rtl/desc_ring_regs.sv
module desc_ring_regs
  import desc_ring_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        idx_i,
  input  logic [31:0]       wdata_i,
  input  logic [OFS_W-1:0]  cons_i,
  output logic [31:0]       rdata_o,
  output logic              en_o,
  output logic              p2m_o,
  output logic              halt_o,
  output logic              soft_rst_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [OFS_W-1:0]  size_o,
  output logic [OFS_W-1:0]  bell_o
);
  logic              rst_q, en_q, p2m_q, sys_q, halt_q;
  logic [ADDR_W-1:0] base_q;
  logic [OFS_W-1:0]  size_q, bell_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q <= 1'b0;
    end else if (we_i && reg_idx_e'(idx_i) == REG_RST) begin
      rst_q <= wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      p2m_q  <= 1'b0;
      sys_q  <= 1'b0;
      halt_q <= 1'b0;
      base_q <= '0;
      size_q <= '0;
      bell_q <= '0;
    end else if (rst_q) begin
      en_q   <= 1'b0;
      p2m_q  <= 1'b0;
      sys_q  <= 1'b0;
      halt_q <= 1'b0;
      base_q <= '0;
      size_q <= '0;
      bell_q <= '0;
    end else if (we_i) begin
      case (reg_idx_e'(idx_i))
        REG_CTRL: begin
          en_q  <= wdata_i[CTRL_EN];
          p2m_q <= wdata_i[CTRL_P2M];
          sys_q <= wdata_i[CTRL_SYS];
        end
        REG_HALT: halt_q <= wdata_i[0];
        REG_BASE: base_q <= {wdata_i[ADDR_W-1:3], 3'b000};
        REG_SIZE: size_q <= wdata_i[OFS_W-1:0];
        REG_BELL: bell_q <= wdata_i[OFS_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (reg_idx_e'(idx_i))
      REG_CTRL: begin
        rdata_o[CTRL_EN]  = en_q;
        rdata_o[CTRL_P2M] = p2m_q;
        rdata_o[CTRL_SYS] = sys_q;
      end
      REG_RST:  rdata_o[0] = rst_q;
      REG_HALT: rdata_o[0] = halt_q;
      REG_BASE: rdata_o[ADDR_W-1:0] = base_q;
      REG_SIZE: rdata_o[OFS_W-1:0] = size_q;
      REG_BELL: rdata_o[OFS_W-1:0] = bell_q;
      REG_CONS: rdata_o[OFS_W-1:0] = cons_i;
      default:  rdata_o = '0;
    endcase
  end

  assign en_o       = en_q;
  assign p2m_o      = p2m_q;
  assign halt_o     = halt_q;
  assign soft_rst_o = rst_q;
  assign base_o     = base_q;
  assign size_o     = size_q;
  assign bell_o     = bell_q;
endmodule

// File: rtl/desc_ring_ptr.sv
module desc_ring_ptr
  import desc_ring_pkg::*;
#(
  parameter int unsigned OFS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [OFS_W-1:0] size_i,
  output logic [OFS_W-1:0] cons_o
);
  logic [OFS_W-1:0] cons_q;
  logic [OFS_W:0]   step;

  assign step = {1'b0, cons_q} + (OFS_W+1)'(SLOT_B);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cons_q <= '0;
    end else if (clr_i) begin
      cons_q <= '0;
    end else if (adv_i) begin
      // wrap once the slot after this one would sit at or past the ring end
      cons_q <= (step >= {1'b0, size_i}) ? '0 : step[OFS_W-1:0];
    end
  end

  assign cons_o = cons_q;
endmodule

// File: rtl/desc_ring_engine.sv
module desc_ring_engine
  import desc_ring_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              p2m_i,
  input  logic              halt_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFS_W-1:0]  cons_i,
  input  logic [OFS_W-1:0]  bell_i,
  output logic              adv_o,
  output logic              idle_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o,
  input  logic              tx_ready_i,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  output logic              rx_ready_o,
  output logic              done_evt_o,
  output logic              eot_evt_o
);
  eng_state_e        state_q;
  logic              req_q, we_q, int_q, eot_q;
  logic [ADDR_W-1:0] addr_q, buf_q;
  logic [BYTE_W-1:0] byte_q;
  logic [CNT_W-1:0]  cnt_q, idx_q;

  logic [CNT_W-1:0]  idx_nxt, new_cnt;
  logic              last_beat, issue, granted;
  logic [ADDR_W-1:0] slot_addr, beat_addr;

  assign idx_nxt   = idx_q + CNT_W'(1);
  assign last_beat = (idx_nxt == cnt_q);
  assign slot_addr = base_i + ADDR_W'(cons_i);
  assign beat_addr = buf_q + ADDR_W'(idx_q);
  assign issue     = !req_q && !halt_i;
  assign granted   = req_q && mem_ack_i;
  assign new_cnt   = mem_rdata_i[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      int_q   <= 1'b0;
      eot_q   <= 1'b0;
      addr_q  <= '0;
      buf_q   <= '0;
      byte_q  <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else if (clr_i) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      int_q   <= 1'b0;
      eot_q   <= 1'b0;
      addr_q  <= '0;
      buf_q   <= '0;
      byte_q  <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (en_i && !halt_i && cons_i != bell_i) state_q <= ST_FETCH_A;
        end
        ST_FETCH_A: begin
          if (issue) begin
            req_q  <= 1'b1;
            we_q   <= 1'b0;
            addr_q <= slot_addr;
          end else if (granted) begin
            req_q   <= 1'b0;
            buf_q   <= ADDR_W'(mem_rdata_i);
            state_q <= ST_FETCH_B;
          end
        end
        ST_FETCH_B: begin
          if (issue) begin
            req_q  <= 1'b1;
            we_q   <= 1'b0;
            addr_q <= slot_addr + ADDR_W'(4);
          end else if (granted) begin
            req_q <= 1'b0;
            cnt_q <= new_cnt;
            int_q <= mem_rdata_i[CNT_W+FLG_INT];
            eot_q <= mem_rdata_i[CNT_W+FLG_EOT];
            idx_q <= '0;
            if (new_cnt == '0)  state_q <= ST_DONE;
            else if (p2m_i)     state_q <= ST_RX;
            else                state_q <= ST_RD;
          end
        end
        ST_RD: begin
          if (issue) begin
            req_q  <= 1'b1;
            we_q   <= 1'b0;
            addr_q <= beat_addr;
          end else if (granted) begin
            req_q   <= 1'b0;
            byte_q  <= mem_rdata_i[BYTE_W-1:0];
            state_q <= ST_TX;
          end
        end
        ST_TX: begin
          // a presented byte stays until taken, halt or not
          if (tx_ready_i) begin
            idx_q   <= idx_nxt;
            state_q <= last_beat ? ST_DONE : ST_RD;
          end
        end
        ST_RX: begin
          if (rx_valid_i && !halt_i) begin
            byte_q  <= rx_data_i;
            state_q <= ST_WR;
          end
        end
        ST_WR: begin
          if (issue) begin
            req_q  <= 1'b1;
            we_q   <= 1'b1;
            addr_q <= beat_addr;
          end else if (granted) begin
            req_q   <= 1'b0;
            we_q    <= 1'b0;
            idx_q   <= idx_nxt;
            state_q <= last_beat ? ST_DONE : ST_RX;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign adv_o       = (state_q == ST_DONE);
  assign done_evt_o  = (state_q == ST_DONE) && int_q;
  assign eot_evt_o   = (state_q == ST_DONE) && eot_q;
  assign idle_o      = (state_q == ST_IDLE) && en_i && (cons_i == bell_i);
  assign mem_req_o   = req_q;
  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = byte_q;
  assign tx_valid_o  = (state_q == ST_TX);
  assign tx_data_o   = byte_q;
  assign rx_ready_o  = (state_q == ST_RX) && !halt_i;
endmodule

// File: rtl/desc_ring_pipe.sv
module desc_ring_pipe
  import desc_ring_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  input  logic              tx_ready_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic              rx_ready_o,
  output logic              done_evt_o,
  output logic              eot_evt_o,
  output logic              out_of_desc_o
);
  logic              en_w, p2m_w, halt_w, soft_rst_w, adv_w;
  logic [ADDR_W-1:0] base_w;
  logic [OFS_W-1:0]  size_w, bell_w, cons_w;

  desc_ring_regs #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .idx_i      (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .cons_i     (cons_w),
    .rdata_o    (reg_rdata_o),
    .en_o       (en_w),
    .p2m_o      (p2m_w),
    .halt_o     (halt_w),
    .soft_rst_o (soft_rst_w),
    .base_o     (base_w),
    .size_o     (size_w),
    .bell_o     (bell_w)
  );

  desc_ring_ptr #(.OFS_W(OFS_W)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (soft_rst_w),
    .adv_i  (adv_w),
    .size_i (size_w),
    .cons_o (cons_w)
  );

  desc_ring_engine #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (soft_rst_w),
    .en_i        (en_w),
    .p2m_i       (p2m_w),
    .halt_i      (halt_w),
    .base_i      (base_w),
    .cons_i      (cons_w),
    .bell_i      (bell_w),
    .adv_o       (adv_w),
    .idle_o      (out_of_desc_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .tx_valid_o  (tx_valid_o),
    .tx_data_o   (tx_data_o),
    .tx_ready_i  (tx_ready_i),
    .rx_valid_i  (rx_valid_i),
    .rx_data_i   (rx_data_i),
    .rx_ready_o  (rx_ready_o),
    .done_evt_o  (done_evt_o),
    .eot_evt_o   (eot_evt_o)
  );
endmodule

// File: rtl/desc_ring_pipe_chk.sv
module desc_ring_pipe_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ack_i,
  input logic              tx_valid_o,
  input logic [7:0]        tx_data_o,
  input logic              tx_ready_i,
  input logic              rx_ready_o,
  input logic              done_evt_o,
  input logic              eot_evt_o,
  input logic              out_of_desc_o,
  input logic              halt_w,
  input logic              soft_rst_w,
  input logic              p2m_w,
  input logic [OFS_W-1:0]  cons_w
);
  a_r12_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni || soft_rst_w)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  a_r4_tx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni || soft_rst_w)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  a_r3_cons_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cons_w) |-> (cons_w == '0 || cons_w == $past(cons_w) + OFS_W'(8)));

  a_r3_cons_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cons_w[2:0] == 3'b000);

  a_r8_halt_no_new_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !$past(mem_req_o) |-> !$past(halt_w));

  a_r13_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_of_desc_o |-> !mem_req_o && !tx_valid_o && !rx_ready_o && !done_evt_o && !eot_evt_o);

  a_r5_rx_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o |-> p2m_w);

  a_r6_evt_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_evt_o || eot_evt_o) |=> !done_evt_o && !eot_evt_o);
endmodule

bind desc_ring_pipe desc_ring_pipe_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (.*);

// File: tb/desc_ring_pipe_tb.sv
module desc_ring_pipe_tb;
  localparam time TCK = 8ns;
  localparam int  RB  = 'h100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(TCK/2) clk = ~clk;

  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic [7:0]  mem_wdata;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0, rx_ready;
  logic [7:0]  rx_data = '0;
  logic        done_evt, eot_evt, out_of_desc;

  desc_ring_pipe u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .done_evt_o(done_evt), .eot_evt_o(eot_evt), .out_of_desc_o(out_of_desc)
  );

  logic [7:0]  mem [0:4095];
  logic [7:0]  exp_tx [$];
  logic [19:0] exp_wr [$];
  logic [1:0]  exp_evt [$];
  logic [7:0]  rx_src [$];
  int checks = 0, fails = 0, cyc = 0, tx_cnt = 0;
  bit rx_hs = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // memory model, stream drivers and per-clock comparison against the model queues
  always @(negedge clk) begin
    logic [11:0] a;
    a = mem_addr[11:0];
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      mem_ack = 1'b1;
      if (mem_we) begin
        if (exp_wr.size() == 0) chk("R5 unexpected write", {12'h0, a, mem_wdata}, 32'h0);
        else chk("R5 write", {12'h0, a, mem_wdata}, {12'h0, exp_wr.pop_front()});
        mem[a] = mem_wdata;
      end else begin
        mem_rdata = {mem[a+12'd3], mem[a+12'd2], mem[a+12'd1], mem[a]};
      end
    end
    tx_ready = (cyc % 3) != 1;
    if (rx_hs) void'(rx_src.pop_front());
    rx_valid = rx_src.size() > 0;
    rx_data  = rx_valid ? rx_src[0] : 8'h00;
    #1;
    rx_hs = rx_valid && rx_ready;
    if (tx_valid && tx_ready) begin
      tx_cnt++;
      if (exp_tx.size() == 0) chk("R4 unexpected tx", {24'h0, tx_data}, 32'h100);
      else chk("R4 tx byte", {24'h0, tx_data}, {24'h0, exp_tx.pop_front()});
    end
    if (done_evt || eot_evt) begin
      if (exp_evt.size() == 0) chk("R6 unexpected event", {30'h0, done_evt, eot_evt}, 32'h4);
      else chk("R6 event flags", {30'h0, done_evt, eot_evt}, {30'h0, exp_evt.pop_front()});
    end
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    #2;
    while (!out_of_desc && n < 4000) begin
      @(negedge clk); #2; n++;
    end
    chk(tag, {31'h0, out_of_desc}, 32'h1);
  endtask

  task automatic put_desc(input int idx, input logic [11:0] ba, input int cnt,
                          input logic [15:0] fl, input bit p2m);
    logic [11:0] s;
    s = 12'(RB + idx * 8);
    {mem[s+12'd3], mem[s+12'd2], mem[s+12'd1], mem[s]} = {20'h0, ba};
    {mem[s+12'd7], mem[s+12'd6], mem[s+12'd5], mem[s+12'd4]} = {fl, 16'(cnt)};
    for (int k = 0; k < cnt; k++) begin
      logic [7:0] d;
      if (p2m) begin
        d = 8'(8'hA0 + k + idx * 5);
        rx_src.push_back(d);
        exp_wr.push_back({ba + 12'(k), d});
      end else begin
        exp_tx.push_back(mem[ba + 12'(k)]);
      end
    end
    if (fl[15] || fl[14]) exp_evt.push_back({fl[15], fl[14]});
  endtask

  initial begin
    logic [31:0] v;
    int t0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(3'd0, v); chk("R9 ctrl after reset", v, 32'h0);
    rd(3'd6, v); chk("R9 consumer after reset", v, 32'h0);
    rd(3'd4, v); chk("R1 size after reset", v, 32'h0);
    chk("R10 out_of_desc while disabled", {31'h0, out_of_desc}, 32'h0);

    wr(3'd3, 32'h0000_0103);
    rd(3'd3, v); chk("R11 base low bits", v, 32'h100);
    wr(3'd4, 32'h40);
    wr(3'd0, 32'h21);
    rd(3'd0, v); chk("R10 ctrl readback", v, 32'h21);
    #2 chk("R13 empty ring when enabled", {31'h0, out_of_desc}, 32'h1);

    // memory to peripheral, including a zero-length descriptor
    put_desc(0, 12'h400, 3, 16'h8000, 1'b0);
    put_desc(1, 12'h500, 0, 16'hC000, 1'b0);
    put_desc(2, 12'h410, 2, 16'h2000, 1'b0);
    wr(3'd5, 32'd24);
    wait_idle("R2 drain to doorbell");
    rd(3'd6, v); chk("R2 consumer at producer", v, 32'd24);
    chk("R4 all tx bytes seen", exp_tx.size(), 0);
    chk("R7 zero-length events raised", exp_evt.size(), 0);
    chk("R7 no beat for empty descriptor", tx_cnt, 5);

    // halt before start
    wr(3'd2, 32'h1);
    put_desc(3, 12'h420, 4, 16'h8000, 1'b0);
    wr(3'd5, 32'd32);
    idle(40);
    rd(3'd6, v); chk("R8 consumer frozen by halt", v, 32'd24);
    chk("R8 no tx while halted", tx_cnt, 5);
    wr(3'd2, 32'h0);
    wait_idle("R8 resume after halt");
    rd(3'd6, v); chk("R8 consumer after resume", v, 32'd32);

    // halt in mid-descriptor
    put_desc(4, 12'h430, 6, 16'h0000, 1'b0);
    wr(3'd5, 32'd40);
    idle(9);
    wr(3'd2, 32'h1);
    idle(30);
    t0 = tx_cnt;
    idle(30);
    chk("R8 tx frozen mid descriptor", tx_cnt, t0);
    wr(3'd2, 32'h0);
    wait_idle("R8 mid descriptor resume");
    chk("R8 no byte lost or repeated", exp_tx.size(), 0);

    // wrap through the end of the ring
    put_desc(5, 12'h440, 1, 16'h4000, 1'b0);
    put_desc(6, 12'h448, 1, 16'h0000, 1'b0);
    put_desc(7, 12'h450, 2, 16'h8000, 1'b0);
    put_desc(0, 12'h460, 1, 16'h8000, 1'b0);
    wr(3'd5, 32'd8);
    wait_idle("R3 wrap drain");
    rd(3'd6, v); chk("R3 consumer after wrap", v, 32'd8);
    chk("R3 wrap bytes", exp_tx.size(), 0);
    chk("R6 wrap events", exp_evt.size(), 0);

    // disabled pipe ignores the doorbell
    wr(3'd0, 32'h0);
    put_desc(1, 12'h470, 2, 16'h8000, 1'b0);
    wr(3'd5, 32'd16);
    idle(40);
    rd(3'd6, v); chk("R10 no progress when disabled", v, 32'd8);
    chk("R10 out_of_desc low when disabled", {31'h0, out_of_desc}, 32'h0);
    wr(3'd0, 32'h1);
    wait_idle("R10 progress once enabled");
    rd(3'd6, v); chk("R10 consumer once enabled", v, 32'd16);

    // peripheral to memory
    wr(3'd0, 32'h9);
    put_desc(2, 12'h600, 4, 16'hC000, 1'b1);
    put_desc(3, 12'h610, 0, 16'h4000, 1'b1);
    wr(3'd5, 32'd32);
    wait_idle("R5 drain");
    rd(3'd6, v); chk("R5 consumer", v, 32'd32);
    chk("R5 all writes seen", exp_wr.size(), 0);
    chk("R5 rx source drained", rx_src.size(), 0);
    chk("R5 memory byte", {24'h0, mem[12'h603]}, {24'h0, 8'(8'hA0 + 3 + 10)});
    chk("R6 p2m events", exp_evt.size(), 0);

    // soft reset
    wr(3'd1, 32'h1);
    wr(3'd4, 32'h80);
    wr(3'd1, 32'h0);
    rd(3'd0, v); chk("R9 ctrl cleared", v, 32'h0);
    rd(3'd3, v); chk("R9 base cleared", v, 32'h0);
    rd(3'd4, v); chk("R9 write ignored in reset", v, 32'h0);
    rd(3'd5, v); chk("R9 doorbell cleared", v, 32'h0);
    rd(3'd6, v); chk("R9 consumer cleared", v, 32'h0);
    chk("R9 out_of_desc after reset", {31'h0, out_of_desc}, 32'h0);

    idle(4);
    finish_run();
  end
endmodule